// File: doc/BRIEF.md
# Operand Effective-Address Sequencer

This unit turns one decoded operand specifier into the byte address that the operand access will use. For each request it takes an addressing-mode code, a base register value, an index register value, a 16-bit signed constant from the instruction, a scale code and an access-size code. It returns the effective address and a flag that says whether the operand lives in memory at all. For the auto-update modes it also returns the new base register value for the register file to write back.

Most modes finish in a single cycle. The pointer-through-memory mode takes longer. It first issues a read of the computed location on a small read port with a request handshake. It then waits for the returned word and hands that word out as the final address. The unit accepts no new request while this fetch is in flight.

Top module: `opnd_addr_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_ready` is 1 and `res_valid`, `wb_valid` and `rd_valid` are 0.
- R2: Modes 0 (register), 1 (immediate) and the unused codes 12 to 15 complete with `res_mem`=0, `res_addr`=0 and `wb_valid`=0.
- R3: Mode 2 yields base + sign-extended constant. Mode 3 yields base alone, because its constant is forced to zero.
- R4: Mode 4 yields base + index. Mode 5 yields the sign-extended constant itself.
- R5: Modes 6 (pre-increment) and 7 (pre-decrement) yield base + step or base - step, where step = 1 << `req_size` (1, 2, 4 or 8 bytes). `wb_value` equals that same address and `wb_valid`=1.
- R6: Modes 8 (post-increment) and 9 (post-decrement) yield base unchanged as the address, with `wb_valid`=1 and `wb_value` = base + step or base - step.
- R7: Mode 10 yields base + (index << `req_scale`) + sign-extended constant. Scale codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R8: Mode 11 raises `rd_valid` in the cycle after acceptance, with `rd_addr` = base + sign-extended constant. `rd_addr` is held stable, with `req_ready` low, until `rd_ready` is seen.
- R9: After the read is accepted, mode 11 completes in the cycle after `rsp_valid`, with `res_addr` = `rsp_data`, `res_mem`=1 and no write-back. No result appears before that.
- R10: Every mode other than 11 raises `res_valid` for exactly the one cycle after the request is accepted. Back-to-back requests give back-to-back results.
- R11: A request presented while `req_ready` is 0 is ignored and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_mode | input | 4 | Addressing-mode code |
| req_base | input | AW | Base register value |
| req_index | input | AW | Index register value |
| req_const | input | CW | Signed instruction constant |
| req_scale | input | 2 | Index shift amount |
| req_size | input | 2 | Log2 of the operand size in bytes |
| rd_valid | output | 1 | Pointer read request |
| rd_addr | output | AW | Pointer read address |
| rd_ready | input | 1 | Memory accepts the read |
| rsp_valid | input | 1 | Pointer word returned |
| rsp_data | input | AW | Returned pointer word |
| res_valid | output | 1 | Result pulse |
| res_mem | output | 1 | Operand is in memory |
| res_addr | output | AW | Effective address |
| wb_valid | output | 1 | Base register write-back pulse |
| wb_value | output | AW | Updated base register value |

## Verification
A wrong sequencer state shows at the ports within one cycle. Depending on the fault, it appears as a missing or extra `res_valid` pulse, a read request that drops or changes its address before `rd_ready`, or `req_ready` high during a fetch. A wrong datapath selection shows in the very next result: the address or the write-back value differs from the value computed from the request fields. A single request in each mode, run with sizes, scales and constants of both signs, therefore exposes it. The bench also sends a stray request during a stalled fetch. A scoreboard rejects any result it did not expect, so a leak of that stray request is caught.

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [3:0]    req_mode,
  input  logic [AW-1:0] req_base,
  input  logic [AW-1:0] req_index,
  input  logic [CW-1:0] req_const,
  input  logic [1:0]    req_scale,
  input  logic [1:0]    req_size,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ready,
  input  logic          rsp_valid,
  input  logic [AW-1:0] rsp_data,
  output logic          res_valid,
  output logic          res_mem,
  output logic [AW-1:0] res_addr,
  output logic          wb_valid,
  output logic [AW-1:0] wb_value
);
  localparam logic [3:0] M_REG = 4'd0, M_IMM = 4'd1, M_DISP = 4'd2, M_IND = 4'd3,
                         M_IDX = 4'd4, M_ABS = 4'd5, M_PREI = 4'd6, M_PRED = 4'd7,
                         M_POSTI = 4'd8, M_POSTD = 4'd9, M_SCL = 4'd10, M_DEF = 4'd11;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;
  st_t st;

  logic [AW-1:0] cext, step, inc, dec, ea, wb_calc;
  logic          is_mem, wb_en;

  assign cext = {{(AW-CW){req_const[CW-1]}}, req_const};
  assign step = AW'(1) << req_size;
  assign inc  = req_base + step;
  assign dec  = req_base - step;

  always_comb begin
    ea      = '0;
    is_mem  = 1'b1;
    wb_en   = 1'b0;
    wb_calc = req_base;
    case (req_mode)
      M_DISP, M_DEF: ea = req_base + cext;
      M_IND:   ea = req_base;
      M_IDX:   ea = req_base + req_index;
      M_ABS:   ea = cext;
      M_PREI:  begin ea = inc; wb_en = 1'b1; wb_calc = inc; end
      M_PRED:  begin ea = dec; wb_en = 1'b1; wb_calc = dec; end
      M_POSTI: begin ea = req_base; wb_en = 1'b1; wb_calc = inc; end
      M_POSTD: begin ea = req_base; wb_en = 1'b1; wb_calc = dec; end
      M_SCL:   ea = req_base + (req_index << req_scale) + cext;
      default: is_mem = 1'b0;
    endcase
  end

  assign req_ready = (st == S_IDLE);
  assign rd_valid  = (st == S_ISSUE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rd_addr   <= '0;
      res_valid <= 1'b0;
      res_mem   <= 1'b0;
      res_addr  <= '0;
      wb_valid  <= 1'b0;
      wb_value  <= '0;
    end else begin
      res_valid <= 1'b0;
      wb_valid  <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (req_mode == M_DEF) begin
            rd_addr <= ea;
            st      <= S_ISSUE;
          end else begin
            res_valid <= 1'b1;
            res_mem   <= is_mem;
            res_addr  <= ea;
            wb_valid  <= wb_en;
            wb_value  <= wb_calc;
          end
        end
        S_ISSUE: if (rd_ready) st <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          res_valid <= 1'b1;
          res_mem   <= 1'b1;
          res_addr  <= rsp_data;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/opnd_addr_gen_chk.sv
module opnd_addr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [3:0]    req_mode,
  input logic [AW-1:0] req_base,
  input logic          rd_valid,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ready,
  input logic          res_valid,
  input logic          res_mem,
  input logic [AW-1:0] res_addr,
  input logic          wb_valid,
  input logic [AW-1:0] wb_value
);
  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  // R8
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !req_ready);

  // R2
  wb_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> res_valid && res_mem);

  // R5
  pre_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_mode == 4'd6 || req_mode == 4'd7)
    |=> res_valid && wb_valid && res_addr == wb_value);

  // R6
  post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_mode == 4'd8 || req_mode == 4'd9)
    |=> res_valid && wb_valid && res_addr == $past(req_base));

  // R9
  defer_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_mode == 4'd11 |=> rd_valid && !res_valid);

  // R10
  single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_mode != 4'd11 |=> res_valid);
endmodule

bind opnd_addr_gen opnd_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_mode(req_mode), .req_base(req_base), .rd_valid(rd_valid),
  .rd_addr(rd_addr), .rd_ready(rd_ready), .res_valid(res_valid),
  .res_mem(res_mem), .res_addr(res_addr), .wb_valid(wb_valid),
  .wb_value(wb_value));

// File: tb/sim_opnd_addr_gen.sv
module sim_opnd_addr_gen;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rd_ready = 0, rsp_valid = 0;
  logic [3:0] req_mode = 0;
  logic [31:0] req_base = 0, req_index = 0, rsp_data = 0;
  logic [15:0] req_const = 0;
  logic [1:0] req_scale = 0, req_size = 0;
  logic req_ready, rd_valid, res_valid, res_mem, wb_valid;
  logic [31:0] rd_addr, res_addr, wb_value;

  always #4 clk = ~clk;

  opnd_addr_gen u0 (.*);

  typedef struct {
    logic mem; logic [31:0] addr; logic wb; logic [31:0] wbv; string tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [3:0] m, input logic [31:0] b, input logic [31:0] x,
                                 input logic [15:0] c, input logic [1:0] sc, input logic [1:0] sz,
                                 input string tag);
    exp_t e;
    logic [31:0] s, st;
    s = {{16{c[15]}}, c};
    st = 32'd1 << sz;
    e.mem = 1; e.wb = 0; e.wbv = 0; e.addr = 0; e.tag = tag;
    case (m)
      4'd2: e.addr = b + s;
      4'd3: e.addr = b;
      4'd4: e.addr = b + x;
      4'd5: e.addr = s;
      4'd6: begin e.addr = b + st; e.wb = 1; e.wbv = b + st; end
      4'd7: begin e.addr = b - st; e.wb = 1; e.wbv = b - st; end
      4'd8: begin e.addr = b; e.wb = 1; e.wbv = b + st; end
      4'd9: begin e.addr = b; e.wb = 1; e.wbv = b - st; end
      4'd10: e.addr = b + x * (32'd1 << sc) + s;
      default: e.mem = 0;
    endcase
    return e;
  endfunction

  task automatic drive(input logic [3:0] m, input logic [31:0] b, input logic [31:0] x,
                       input logic [15:0] c, input logic [1:0] sc, input logic [1:0] sz);
    req_valid = 1; req_mode = m; req_base = b; req_index = x;
    req_const = c; req_scale = sc; req_size = sz;
  endtask

  task automatic send(input logic [3:0] m, input logic [31:0] b, input logic [31:0] x,
                      input logic [15:0] c, input logic [1:0] sc, input logic [1:0] sz,
                      input string tag);
    q.push_back(model(m, b, x, c, sc, sz, tag));
    drive(m, b, x, c, sc, sz);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic deferred(input logic [31:0] b, input logic [15:0] c, input logic [31:0] ptr, input int stall);
    exp_t e;
    logic [31:0] a;
    a = b + {{16{c[15]}}, c};
    e.mem = 1; e.addr = ptr; e.wb = 0; e.wbv = 0; e.tag = "R9";
    drive(4'd11, b, 32'h0, c, 2'd0, 2'd0);
    @(negedge clk);
    req_valid = 0;
    chk(rd_valid === 1'b1, "R8 rd_valid", {31'b0, rd_valid}, 32'd1);
    chk(rd_addr === a, "R8 rd_addr", rd_addr, a);
    for (int i = 0; i < stall; i++) begin
      drive(4'd0, 32'h5, 32'h0, 16'h0, 2'd0, 2'd0); // R11 stray request while busy
      @(negedge clk);
      chk(rd_valid === 1'b1 && rd_addr === a && req_ready === 1'b0, "R8 hold", rd_addr, a);
    end
    req_valid = 0;
    rd_ready = 1;
    @(negedge clk);
    rd_ready = 0;
    chk(rd_valid === 1'b0, "R8 released", {31'b0, rd_valid}, 32'd0);
    repeat (2) @(negedge clk);
    chk(res_valid === 1'b0, "R9 early result", {31'b0, res_valid}, 32'd0);
    q.push_back(e);
    rsp_valid = 1; rsp_data = ptr;
    @(negedge clk);
    rsp_valid = 0; rsp_data = 32'hDEAD_BEEF;
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (q.size() == 0) begin
        chk(0, "R11 unexpected result", res_addr, 32'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(res_mem === e.mem && res_addr === e.addr, {e.tag, " addr"}, res_addr, e.addr);
        chk(wb_valid === e.wb && (!e.wb || wb_value === e.wbv), {e.tag, " writeback"}, wb_value, e.wbv);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1 && res_valid === 0 && wb_valid === 0 && rd_valid === 0,
        "R1 in reset", {res_valid, wb_valid, rd_valid, req_ready}, 32'd1);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1 && res_valid === 0 && wb_valid === 0 && rd_valid === 0,
        "R1 after reset", {res_valid, wb_valid, rd_valid, req_ready}, 32'd1);
    send(4'd0, 32'h1234, 32'h1, 16'h10, 2'd0, 2'd0, "R2");
    send(4'd1, 32'h1234, 32'h1, 16'h10, 2'd0, 2'd0, "R2");
    send(4'd13, 32'h99, 32'h1, 16'h10, 2'd0, 2'd0, "R2");
    send(4'd2, 32'h0000_1000, 32'h0, 16'h0064, 2'd0, 2'd0, "R3");
    send(4'd2, 32'h0000_1000, 32'h0, 16'hFFF0, 2'd0, 2'd0, "R3");
    send(4'd3, 32'hABCD_0000, 32'h0, 16'h7777, 2'd0, 2'd0, "R3");
    send(4'd4, 32'h0000_2000, 32'h30, 16'h0, 2'd0, 2'd0, "R4");
    send(4'd5, 32'h5555, 32'h0, 16'h8001, 2'd0, 2'd0, "R4");
    send(4'd6, 32'h100, 32'h0, 16'h0, 2'd0, 2'd2, "R5");
    send(4'd7, 32'h100, 32'h0, 16'h0, 2'd0, 2'd3, "R5");
    send(4'd7, 32'h0, 32'h0, 16'h0, 2'd0, 2'd0, "R5");
    send(4'd8, 32'h200, 32'h0, 16'h0, 2'd0, 2'd1, "R6");
    send(4'd9, 32'h200, 32'h0, 16'h0, 2'd0, 2'd3, "R6");
    for (int s = 0; s < 4; s++)
      send(4'd10, 32'h4000, 32'h11, 16'hFFFC, 2'(s), 2'd0, "R7");
    send(4'd10, 32'h0, 32'h8000_0001, 16'h0002, 2'd3, 2'd0, "R7");
    @(negedge clk);
    deferred(32'h0000_3000, 16'h0008, 32'hCAFE_0010, 3);
    send(4'd4, 32'h1, 32'h2, 16'h0, 2'd0, 2'd0, "R10");
    deferred(32'h0000_0100, 16'hFF00, 32'h0000_BEEF, 0);
    send(4'd0, 32'h0, 32'h0, 16'h0, 2'd0, 2'd0, "R10");
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R10 missing results", q.size(), 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule